// File: doc/BRIEF.md
# Five-Port Mesh Packet Router with Hop-Offset Routing

This block is the switching element of one node in a small two-dimensional mesh. It has five full-duplex packet ports: a local port for the attached node and one port for each compass neighbour. Every packet is 25 bits wide. The packet carries its remaining journey as a relative offset: a sign and a 2-bit magnitude for the vertical axis and the same for the horizontal axis. The router finishes the vertical leg before it starts the horizontal one. It removes one hop from the magnitude of the axis it uses before it sends the packet on. A packet whose offset has run down to zero leaves through the local port.

Each input port has a capture register and a one-packet hold slot. In every cycle the router routes one candidate per port. The candidate is the held packet if the slot is full and the captured packet otherwise. When several candidates want the same output, a fixed priority decides which one passes. The output is also closed while the neighbour on that side reports busy. A candidate that is refused is parked in its port's hold slot and tried again the next cycle, so no packet is lost. Each port reports a full hold slot to its upstream neighbour as a busy bit. While that bit is set, the port does not take new input.

Top module: `mesh_hop_router`

## Requirements
- R1: After reset every output packet slot reads all zeros and every busy-out bit is 0.
- R2: Bit 0 of a packet is its valid flag. Bits 24:22 hold the vertical field: bit 24 is the sign and bits 23:22 the magnitude. A valid candidate with a nonzero vertical magnitude goes North (output index 1) if the sign is 1 and South (index 3) if it is 0. The forwarded copy has the vertical magnitude lowered by one and all other bits unchanged.
- R3: Bits 21:19 hold the horizontal field: bit 21 is the sign and bits 20:19 the magnitude. When the vertical magnitude is 0 and the horizontal magnitude is nonzero, the packet goes East (index 2) if the sign is 1 and West (index 4) if it is 0. The horizontal magnitude is lowered by one.
- R4: When both magnitudes are 0, the packet goes to the Local output (index 0) unchanged.
- R5: Suppose a packet arrives on an idle port with its output free. It is captured at one rising edge and appears on its output at the next rising edge. Each output slot is all zeros in any cycle where nothing was forwarded to it.
- R6: When candidates compete for one output, the lowest port index wins. Port indices and busy bit positions are 0 Local, 1 North, 2 East, 3 South, 4 West.
- R7: A refused candidate is kept unchanged in its port's hold slot. The next cycle it takes precedence over that port's capture register, and it is retried every cycle until it is forwarded.
- R8: While busy_in[j] is 1, output j forwards nothing. A candidate that wants output j waits in its hold slot exactly as a contention loser does.
- R9: busy_out[i] is 1 exactly while port i's hold slot is full. During such a cycle the input on port i is ignored, and a packet already captured there is kept for later.
- R10: A candidate whose valid bit is 0 requests no output and is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_flat | input | 125 | Incoming packets, port i on bits i*25 +: 25 |
| busy_in | input | 5 | Neighbour busy bits, one per output direction |
| out_flat | output | 125 | Outgoing packets, port j on bits j*25 +: 25 |
| busy_out | output | 5 | This router's busy bits, one per input port |

## Verification
The assertions assume only that busy_in and in_flat are stable around the rising edge. They make no assumption about which destinations arrive together or about whether upstream obeys busy_out, so they also hold when a sender ignores the busy bit. During the random traffic phase the bench sends a new packet on a port only when that port's busy_out was low at the preceding falling edge, just as a well-behaved neighbour would. It drives random busy_in patterns and random offsets that include U-turns back to the sending side. One directed case breaks the busy_out rule on purpose, to show that the extra packet is dropped at the input.

// File: rtl/mhr_pkg.sv
package mhr_pkg;
  localparam int PORTS     = 5;
  localparam int PKT_W     = 25;
  localparam int MAG_W     = 2;
  localparam int VALID_BIT = 0;
  localparam int Y_SIGN    = PKT_W - 1;
  localparam int Y_MAG_HI  = Y_SIGN - 1;
  localparam int Y_MAG_LO  = Y_MAG_HI - MAG_W + 1;
  localparam int X_SIGN    = Y_MAG_LO - 1;
  localparam int X_MAG_HI  = X_SIGN - 1;
  localparam int X_MAG_LO  = X_MAG_HI - MAG_W + 1;

  typedef enum logic [2:0] {
    DIR_LOCAL = 3'd0,
    DIR_NORTH = 3'd1,
    DIR_EAST  = 3'd2,
    DIR_SOUTH = 3'd3,
    DIR_WEST  = 3'd4
  } dir_e;

  typedef logic [PKT_W-1:0] pkt_t;

  function automatic logic [MAG_W-1:0] y_mag(input pkt_t p);
    return p[Y_MAG_HI:Y_MAG_LO];
  endfunction

  function automatic logic [MAG_W-1:0] x_mag(input pkt_t p);
    return p[X_MAG_HI:X_MAG_LO];
  endfunction

  // Vertical leg first, then horizontal, then local delivery.
  function automatic dir_e pick_dir(input pkt_t p);
    if (y_mag(p) != '0)      return p[Y_SIGN] ? DIR_NORTH : DIR_SOUTH;
    else if (x_mag(p) != '0) return p[X_SIGN] ? DIR_EAST  : DIR_WEST;
    else                     return DIR_LOCAL;
  endfunction

  // Copy of the packet with one hop taken off the axis in use.
  function automatic pkt_t next_hop(input pkt_t p);
    pkt_t r;
    r = p;
    if (y_mag(p) != '0)      r[Y_MAG_HI:Y_MAG_LO] = y_mag(p) - 1'b1;
    else if (x_mag(p) != '0) r[X_MAG_HI:X_MAG_LO] = x_mag(p) - 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/mhr_port_stage.sv
module mhr_port_stage
  import mhr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  pkt_t in_pkt,
  input  logic won,
  output pkt_t cand,
  output logic hold_busy
);
  pkt_t in_q;
  pkt_t hold_q;
  logic hold_v;
  logic lose;

  assign cand      = hold_v ? hold_q : in_q;
  assign lose      = cand[VALID_BIT] && !won;
  assign hold_busy = hold_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      hold_q <= '0;
      hold_v <= 1'b0;
    end else begin
      if (!hold_v) in_q <= in_pkt;
      if (lose) begin
        hold_q <= cand;
        hold_v <= 1'b1;
      end else if (hold_v && won) begin
        hold_v <= 1'b0;
      end
    end
  end

  // R9: a captured packet survives while the hold slot is full
  a_r9_capture_kept: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |=> $stable(in_q));

  // R7: a refused held packet stays parked and unchanged
  a_r7_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !won) |=> (hold_v && $stable(hold_q)));
endmodule

// File: rtl/mhr_route_unit.sv
module mhr_route_unit
  import mhr_pkg::*;
(
  input  pkt_t cand,
  output logic req,
  output dir_e dir,
  output pkt_t fwd
);
  assign req = cand[VALID_BIT];
  assign dir = pick_dir(cand);
  assign fwd = next_hop(cand);
endmodule

// File: rtl/mhr_out_arbiter.sv
module mhr_out_arbiter #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  input  logic         blocked,
  output logic [N-1:0] gnt
);
  logic found;

  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!blocked && req[k] && !found) begin
        gnt[k] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mesh_hop_router.sv
module mesh_hop_router
  import mhr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PORTS*PKT_W-1:0] in_flat,
  input  logic [PORTS-1:0]       busy_in,
  output logic [PORTS*PKT_W-1:0] out_flat,
  output logic [PORTS-1:0]       busy_out
);
  pkt_t             cand    [PORTS];
  pkt_t             fwd     [PORTS];
  dir_e             dir     [PORTS];
  logic [PORTS-1:0] req_v;
  logic [PORTS-1:0] won;
  logic [PORTS-1:0] lost;
  logic [PORTS-1:0] req_by_out [PORTS];
  logic [PORTS-1:0] gnt_by_out [PORTS];
  pkt_t             out_d   [PORTS];
  pkt_t             out_q   [PORTS];

  genvar g;
  generate
    for (g = 0; g < PORTS; g++) begin : g_in
      mhr_port_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_pkt    (in_flat[g*PKT_W +: PKT_W]),
        .won       (won[g]),
        .cand      (cand[g]),
        .hold_busy (busy_out[g])
      );
      mhr_route_unit u_route (
        .cand (cand[g]),
        .req  (req_v[g]),
        .dir  (dir[g]),
        .fwd  (fwd[g])
      );
    end

    for (g = 0; g < PORTS; g++) begin : g_out
      always_comb begin
        for (int i = 0; i < PORTS; i++)
          req_by_out[g][i] = req_v[i] && (dir[i] == dir_e'(g));
      end
      mhr_out_arbiter #(.N(PORTS)) u_arb (
        .req     (req_by_out[g]),
        .blocked (busy_in[g]),
        .gnt     (gnt_by_out[g])
      );
      always_comb begin
        out_d[g] = '0;
        for (int i = 0; i < PORTS; i++)
          if (gnt_by_out[g][i]) out_d[g] = fwd[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q[g] <= '0;
        else        out_q[g] <= out_d[g];
      end
      assign out_flat[g*PKT_W +: PKT_W] = out_q[g];

      // R8: a busy neighbour receives nothing on the following cycle
      a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in[g] |=> !out_q[g][VALID_BIT]);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      won[i] = 1'b0;
      for (int j = 0; j < PORTS; j++) won[i] = won[i] | gnt_by_out[j][i];
      lost[i] = req_v[i] && !won[i];
    end
  end

  // R9: a refused candidate raises its busy bit next cycle
  generate
    for (g = 0; g < PORTS; g++) begin : g_chk
      a_r9_loser_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lost[g] |=> busy_out[g]);
    end
  endgenerate

  // R10: with no valid candidate, every output is idle next cycle
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_v == '0) |=> !(out_q[0][VALID_BIT] | out_q[1][VALID_BIT] |
                        out_q[2][VALID_BIT] | out_q[3][VALID_BIT] |
                        out_q[4][VALID_BIT]));

  // R2: vertical outputs carry the matching vertical sign
  a_r2_north_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[1][VALID_BIT] |-> out_q[1][Y_SIGN]);
  a_r2_south_sign: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[3][VALID_BIT] |-> !out_q[3][Y_SIGN]);

  // R3: horizontal outputs only ever leave with no vertical hops left
  a_r3_east_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[2][VALID_BIT] |-> (y_mag(out_q[2]) == '0 && out_q[2][X_SIGN]));
  a_r3_west_clean: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[4][VALID_BIT] |-> (y_mag(out_q[4]) == '0 && !out_q[4][X_SIGN]));

  // R4: local delivery only with both offsets used up
  a_r4_local_done: assert property (@(posedge clk) disable iff (!rst_n)
    out_q[0][VALID_BIT] |-> (y_mag(out_q[0]) == '0 && x_mag(out_q[0]) == '0));
endmodule

// File: tb/mesh_hop_router_tb_top.sv
`timescale 1ns/1ps
module mesh_hop_router_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [124:0] in_flat = '0;
  logic [4:0]   busy_in = '0;
  logic [124:0] out_flat;
  logic [4:0]   busy_out;

  always #2 clk = ~clk;

  mesh_hop_router dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_flat  (in_flat),
    .busy_in  (busy_in),
    .out_flat (out_flat),
    .busy_out (busy_out)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_on = 0;
  string phase  = "R1";

  // Behavioural reference model
  logic [24:0] m_in [5];
  logic [24:0] m_hold [5];
  logic [24:0] m_out [5];
  bit          m_hv [5];
  logic [24:0] c [5];
  logic [24:0] nxt [5];
  bit          used [5];
  bit          ok [5];
  int          d;

  function automatic int mdir(input logic [24:0] p);
    int ym = int'(p[23:22]);
    int xm = int'(p[20:19]);
    if (ym > 0) return p[24] ? 1 : 3;
    if (xm > 0) return p[21] ? 2 : 4;
    return 0;
  endfunction

  function automatic logic [24:0] mstep(input logic [24:0] p);
    if (p[23:22] != 0) return p - (25'd1 << 22);
    if (p[20:19] != 0) return p - (25'd1 << 19);
    return p;
  endfunction

  function automatic logic [24:0] mk(input bit ys, input int ym, input bit xs,
                                     input int xm, input int pay, input bit v);
    logic [24:0] r;
    r = {ys, 2'(ym), xs, 2'(xm), 18'(pay), v};
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin
        m_in[i] = '0; m_hold[i] = '0; m_out[i] = '0; m_hv[i] = 0;
      end
    end else begin
      for (int i = 0; i < 5; i++) c[i] = m_hv[i] ? m_hold[i] : m_in[i];
      for (int j = 0; j < 5; j++) begin nxt[j] = '0; used[j] = 0; end
      for (int i = 0; i < 5; i++) begin
        ok[i] = 0;
        if (c[i][0]) begin
          d = mdir(c[i]);
          if (!used[d] && !busy_in[d]) begin
            used[d] = 1; nxt[d] = mstep(c[i]); ok[i] = 1;
          end
        end
      end
      for (int i = 0; i < 5; i++) begin
        if (!m_hv[i]) m_in[i] = in_flat[i*25 +: 25];
        if (c[i][0] && !ok[i]) begin m_hold[i] = c[i]; m_hv[i] = 1; end
        else m_hv[i] = 0;
      end
      for (int j = 0; j < 5; j++) m_out[j] = nxt[j];
    end
  end

  task automatic check_eq(input string tag, input logic [124:0] act,
                          input logic [124:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [124:0] e;
      for (int j = 0; j < 5; j++) e[j*25 +: 25] = m_out[j];
      check_eq({phase, " model outputs"}, out_flat, e);
      check_eq({phase, " model busy_out"}, {120'd0, busy_out},
               {120'd0, m_hv[4], m_hv[3], m_hv[2], m_hv[1], m_hv[0]});
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=%0d cycles expected=completion", cyc);
      summary();
    end
  end

  task automatic put(input int i, input logic [24:0] p);
    in_flat[i*25 +: 25] = p;
  endtask

  function automatic logic [24:0] slot(input int j);
    return out_flat[j*25 +: 25];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 reset outputs", out_flat, '0);
    check_eq("R1 reset busy_out", {120'd0, busy_out}, '0);
    rst_n = 1'b1;
    cmp_on = 1;
    @(negedge clk);

    // R2/R3/R5: several disjoint routes at once, two-edge latency
    phase = "R2";
    put(2, mk(1, 2, 0, 1, 'h0A5, 1));
    put(4, mk(0, 1, 1, 1, 'h007, 1));
    put(3, mk(0, 0, 1, 3, 'h123, 1));
    put(1, mk(1, 0, 0, 1, 'h321, 1));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R2 R5 north hop", {100'd0, slot(1)}, {100'd0, mk(1, 1, 0, 1, 'h0A5, 1)});
    check_eq("R2 south hop", {100'd0, slot(3)}, {100'd0, mk(0, 0, 1, 1, 'h007, 1)});
    check_eq("R3 east hop", {100'd0, slot(2)}, {100'd0, mk(0, 0, 1, 2, 'h123, 1)});
    check_eq("R3 west hop", {100'd0, slot(4)}, {100'd0, mk(1, 0, 0, 0, 'h321, 1)});

    // R4: arrival at destination
    phase = "R4";
    put(2, mk(1, 0, 0, 0, 'h055, 1));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R4 local delivery", {100'd0, slot(0)}, {100'd0, mk(1, 0, 0, 0, 'h055, 1)});

    // R6/R7: Local and South both want North
    phase = "R6";
    put(0, mk(1, 1, 0, 0, 'h011, 1));
    put(3, mk(1, 3, 1, 0, 'h033, 1));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R6 local wins north", {100'd0, slot(1)}, {100'd0, mk(1, 0, 0, 0, 'h011, 1)});
    check_eq("R9 loser busy", {120'd0, busy_out}, {120'd0, 5'b01000});
    @(negedge clk);
    check_eq("R7 held retried", {100'd0, slot(1)}, {100'd0, mk(1, 2, 1, 0, 'h033, 1)});
    check_eq("R7 hold freed", {120'd0, busy_out}, '0);

    // R8: busy neighbour to the east
    phase = "R8";
    busy_in = 5'b00100;
    put(0, mk(0, 0, 1, 1, 'h066, 1));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R8 east blocked", {100'd0, slot(2)}, '0);
    check_eq("R8 blocked held", {120'd0, busy_out}, {120'd0, 5'b00001});
    busy_in = '0;
    @(negedge clk);
    check_eq("R8 east released", {100'd0, slot(2)}, {100'd0, mk(0, 0, 1, 0, 'h066, 1)});

    // R9: input ignored while hold slot full
    phase = "R9";
    busy_in = 5'b00010;
    put(0, mk(1, 1, 0, 0, 'h0AA, 1));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R9 busy raised", {120'd0, busy_out}, {120'd0, 5'b00001});
    put(0, mk(0, 0, 0, 0, 'h0BB, 1));
    @(negedge clk); in_flat = '0; busy_in = '0;
    @(negedge clk);
    check_eq("R9 held packet out", {100'd0, slot(1)}, {100'd0, mk(1, 0, 0, 0, 'h0AA, 1)});
    check_eq("R9 ignored input absent", {100'd0, slot(0)}, '0);
    @(negedge clk);
    check_eq("R9 ignored input stays absent", {100'd0, slot(0)}, '0);

    // R10: invalid packet
    phase = "R10";
    put(4, mk(0, 0, 1, 2, 'h099, 0));
    @(negedge clk); in_flat = '0;
    @(negedge clk);
    check_eq("R10 no output", out_flat, '0);
    check_eq("R10 not held", {120'd0, busy_out}, '0);

    // R5: random traffic against the model
    phase = "R5";
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 5; i++) begin
        if (!busy_out[i] && ($urandom % 3 == 0))
          put(i, {$urandom, 1'b1});
        else
          put(i, '0);
      end
      busy_in = ($urandom % 4 == 0) ? 5'($urandom) : 5'd0;
      @(negedge clk);
    end
    in_flat = '0; busy_in = '0;
    repeat (6) @(negedge clk);
    check_eq("R7 all drained", {120'd0, busy_out}, '0);
    summary();
  end
endmodule